// File: doc/BRIEF.md
# Cascadable Pipelined Parity Checker

This block checks incoming data words against parity bits supplied by a memory controller. The word is split into independent lanes. Each lane has its own parity input, its own partial-parity output and its own active-low error flag. The data word is also registered and passed through to a data output. The parity results and the error flags follow that output at a fixed distance in the pipeline.

A static role input selects one of two uses. In the solo role, one instance checks its whole lane on its own and raises the flag itself. In the tail role, two instances share a wider check. The head instance, which is wired in the solo role, hands its partial parity to the tail instance. The tail instance folds that value into its own partial parity and drives the valid flag, one cycle later than a solo instance would. If both active-low chip selects are high when a word is captured, that word is dropped and every output keeps its value. A synchronous active-high reset clears the whole pipeline.

Top module: `pcc_checker`

## Requirements
- R1: When a word is captured at a clock edge with at least one chip select low, `q_o` shows that word immediately after that edge.
- R2: For lane c, the partial parity is the XOR of data bits [c*LANE_W +: LANE_W] and `par_i[c]`. It appears on `ppo_o[c]` two cycles after the word appeared on `q_o`.
- R3: In the solo role (`cascade_i` = 0), `err_n_o[c]` updates on the same edge as `ppo_o[c]` and is driven low exactly when the partial parity is 1.
- R4: In the tail role (`cascade_i` = 1), `err_n_o[c]` updates one cycle after `ppo_o[c]`. It is driven low exactly when the local partial parity XOR `ups_ppo_i[c]` is 1, where `ups_ppo_i[c]` is the head instance's partial parity for the same word.
- R5: A word captured while both `cs_a_n` and `cs_b_n` are high changes neither `q_o`, nor `ppo_o`, nor `err_n_o`.
- R6: While `rst` is high at a clock edge, that edge sets `q_o` to 0, `ppo_o` to 0 and `err_n_o` to all ones. Words captured before the reset never reach the outputs afterwards.
- R7: A parity error in one lane leaves the error flags of the other lanes unaffected.
- R8: An error flag keeps its value until a later captured (ungated) word reaches the flag stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cascade_i | input | 1 | Role: 0 solo, 1 tail of a cascaded pair |
| cs_a_n | input | 1 | First chip select, active low |
| cs_b_n | input | 1 | Second chip select, active low; a word is dropped only when both selects are high |
| data_i | input | LANES*LANE_W | Received data word |
| par_i | input | LANES | Controller parity bit, one per lane |
| ups_ppo_i | input | LANES | Partial parity from the head instance (tail role only) |
| q_o | output | LANES*LANE_W | Registered data word |
| ppo_o | output | LANES | Partial parity per lane |
| err_n_o | output | LANES | Parity error flag per lane, active low |

## Verification
A word is captured at edge k and shows on `q_o` right after that edge. The partial parity lands after edge k+2. The error flag also lands after edge k+2 in the solo role and after edge k+3 in the tail role. The bench drives inputs at falling edges and samples at the next falling edge. It keeps a history of every driven word, so the expected output for edge n is taken from the word driven at n, n-2 or n-3, and the expected value is held whenever that word was gated. Directed single-bit injections check that the flag is still high one edge before its due edge and is low exactly on the due edge, in each role.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic {
    ROLE_SOLO = 1'b0,
    ROLE_TAIL = 1'b1
  } role_e;
endpackage

// File: rtl/pcc_capture.sv
module pcc_capture #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         take_i,
  input  logic [W-1:0] data_i,
  input  logic         par_i,
  output logic [W-1:0] q_o,
  output logic         par_o,
  output logic         v_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o   <= '0;
      par_o <= 1'b0;
      v_o   <= 1'b0;
    end else begin
      v_o <= take_i;
      if (take_i) begin
        q_o   <= data_i;
        par_o <= par_i;
      end
    end
  end

  // R5: a dropped word leaves the data output untouched
  a_r5_q_hold: assert property (@(posedge clk) disable iff (rst)
    !take_i |=> $stable(q_o));
endmodule

// File: rtl/pcc_lane.sv
module pcc_lane
  import pcc_pkg::*;
#(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  role_e        role,
  input  logic [W-1:0] q_i,
  input  logic         par_i,
  input  logic         v_i,
  input  logic         ups_i,
  output logic         ppo_o,
  output logic         err_n_o
);
  logic p2, v2, v3, rst_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      p2      <= 1'b0;
      v2      <= 1'b0;
      v3      <= 1'b0;
      ppo_o   <= 1'b0;
      err_n_o <= 1'b1;
    end else begin
      v2 <= v_i;
      v3 <= v2;
      if (v_i) p2 <= ^{q_i, par_i};
      if (v2) ppo_o <= p2;
      if (role == ROLE_SOLO && v2) err_n_o <= ~p2;
      else if (role == ROLE_TAIL && v3) err_n_o <= ~(ppo_o ^ ups_i);
    end
  end

  always_ff @(posedge clk) rst_seen <= rst;

  // R6: the edge after a reset edge sees cleared results
  always_ff @(posedge clk) begin
    if (rst_seen === 1'b1)
      a_r6_reset_clear: assert (ppo_o == 1'b0 && err_n_o == 1'b1);
  end

  // R2: partial parity moves only when a captured word reaches it
  a_r2_ppo_hold: assert property (@(posedge clk) disable iff (rst)
    !v2 |=> $stable(ppo_o));

  // R3: solo flag mirrors the partial parity produced on the same edge
  a_r3_solo_flag: assert property (@(posedge clk) disable iff (rst)
    (role == ROLE_SOLO && v2) |=> (err_n_o == ~ppo_o));

  // R8: flag holds until its own stage sees a captured word
  a_r8_flag_hold: assert property (@(posedge clk) disable iff (rst)
    ((role == ROLE_SOLO && !v2) || (role == ROLE_TAIL && !v3)) |=> $stable(err_n_o));
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker
  import pcc_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int LANE_W = 7
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cascade_i,
  input  logic                      cs_a_n,
  input  logic                      cs_b_n,
  input  logic [LANES*LANE_W-1:0]   data_i,
  input  logic [LANES-1:0]          par_i,
  input  logic [LANES-1:0]          ups_ppo_i,
  output logic [LANES*LANE_W-1:0]   q_o,
  output logic [LANES-1:0]          ppo_o,
  output logic [LANES-1:0]          err_n_o
);
  localparam int DW = LANES * LANE_W;

  logic  take;
  role_e role;
  logic [LANES-1:0] par_q, v_q;

  assign take = ~(cs_a_n & cs_b_n);
  assign role = role_e'(cascade_i);

  for (genvar c = 0; c < LANES; c++) begin : g_lane
    pcc_capture #(.W(LANE_W)) u_cap (
      .clk    (clk),
      .rst    (rst),
      .take_i (take),
      .data_i (data_i[c*LANE_W +: LANE_W]),
      .par_i  (par_i[c]),
      .q_o    (q_o[c*LANE_W +: LANE_W]),
      .par_o  (par_q[c]),
      .v_o    (v_q[c])
    );
    pcc_lane #(.W(LANE_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .role    (role),
      .q_i     (q_o[c*LANE_W +: LANE_W]),
      .par_i   (par_q[c]),
      .v_i     (v_q[c]),
      .ups_i   (ups_ppo_i[c]),
      .ppo_o   (ppo_o[c]),
      .err_n_o (err_n_o[c])
    );
  end

  // R1: an accepted word reaches the data output on the capture edge
  a_r1_q_load: assert property (@(posedge clk) disable iff (rst)
    take |=> (q_o == $past(data_i[DW-1:0])));
endmodule

// File: tb/tb_pcc_checker.sv
module tb_pcc_checker;
  localparam int LANES = 2, LANE_W = 7, DW = LANES * LANE_W;
  localparam int NV = 16, NH = NV + 4;

  // entry: {cs_a_n, cs_b_n, par[1:0], data[13:0]}
  localparam logic [17:0] VEC [NV] = '{
    {2'b00, 2'b00, 14'h0000}, {2'b01, 2'b01, 14'h0001}, {2'b10, 2'b10, 14'h0080},
    {2'b00, 2'b11, 14'h1F3A}, {2'b11, 2'b10, 14'h3FFF}, {2'b00, 2'b00, 14'h2AD5},
    {2'b11, 2'b01, 14'h0103}, {2'b01, 2'b00, 14'h3C1E}, {2'b10, 2'b01, 14'h0F0F},
    {2'b11, 2'b11, 14'h1234}, {2'b00, 2'b10, 14'h2001}, {2'b00, 2'b00, 14'h0040},
    {2'b01, 2'b11, 14'h3E7C}, {2'b11, 2'b00, 14'h0808}, {2'b00, 2'b01, 14'h1555},
    {2'b10, 2'b00, 14'h2222}};

  logic clk = 1'b0, rst = 1'b1, cascade = 1'b0, cs_a_n = 1'b1, cs_b_n = 1'b1;
  logic [DW-1:0] d_dut = '0, d_up = '0, q, q_up;
  logic [1:0] p_dut = '0, p_up = '0, ppo, ppo_up, err_n, err_n_up;
  int checks = 0, errors = 0;
  logic [DW-1:0] hd [NH], hu [NH];
  logic [1:0] hpd [NH], hpu [NH];
  logic hv [NH];
  logic [DW-1:0] eq;
  logic [1:0] eppo, eerr;

  always #2.5 clk = ~clk;

  pcc_checker #(.LANES(LANES), .LANE_W(LANE_W)) up0 (
    .clk(clk), .rst(rst), .cascade_i(1'b0), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .data_i(d_up), .par_i(p_up), .ups_ppo_i(2'b00),
    .q_o(q_up), .ppo_o(ppo_up), .err_n_o(err_n_up));

  pcc_checker #(.LANES(LANES), .LANE_W(LANE_W)) dut (
    .clk(clk), .rst(rst), .cascade_i(cascade), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
    .data_i(d_dut), .par_i(p_dut), .ups_ppo_i(ppo_up),
    .q_o(q), .ppo_o(ppo), .err_n_o(err_n));

  function automatic logic [1:0] lp(input logic [DW-1:0] d, input logic [1:0] p);
    lp[0] = ^d[LANE_W-1:0] ^ p[0];
    lp[1] = ^d[DW-1:LANE_W] ^ p[1];
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; cs_a_n = 1'b1; cs_b_n = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  // Streams the table; expected values derive from the history of driven words.
  task automatic run_table(input logic tail);
    cascade = tail;
    do_reset();
    chk("R6 q after reset", q, '0);
    chk("R6 ppo after reset", {12'b0, ppo}, '0);
    chk("R6 err after reset", {12'b0, err_n}, {12'b0, 2'b11});
    eq = '0; eppo = '0; eerr = 2'b11;
    for (int i = 0; i < NH; i++) begin
      @(negedge clk);
      rst = 1'b0;
      if (i > 0) begin
        int n = i - 1;
        if (hv[n]) eq = hd[n];
        if (n >= 2 && hv[n-2]) begin
          eppo = lp(hd[n-2], hpd[n-2]);
          if (!tail) eerr = ~eppo;
        end
        if (tail && n >= 3 && hv[n-3])
          eerr = ~(lp(hd[n-3], hpd[n-3]) ^ lp(hu[n-3], hpu[n-3]));
        chk("R1/R5 q", q, eq);
        chk("R2/R5 ppo", {12'b0, ppo}, {12'b0, eppo});
        chk(tail ? "R4/R8 err tail" : "R3/R8 err solo", {12'b0, err_n}, {12'b0, eerr});
      end
      if (i < NV) begin
        hd[i] = VEC[i][13:0];
        hu[i] = {VEC[i][6:0], VEC[i][13:7]};
        hpd[i] = tail ? 2'b00 : VEC[i][15:14];
        hpu[i] = VEC[i][15:14];
        hv[i] = ~(VEC[i][17] & VEC[i][16]);
        {cs_a_n, cs_b_n} = VEC[i][17:16];
      end else begin
        hd[i] = '0; hu[i] = '0; hpd[i] = '0; hpu[i] = '0; hv[i] = 1'b0;
        {cs_a_n, cs_b_n} = 2'b11;
      end
      d_dut = hd[i]; d_up = hu[i]; p_dut = hpd[i]; p_up = hpu[i];
    end
  endtask

  // Single-bit error in lane 1 (data bit 9); flag due after edge 3 (solo) or 4 (tail).
  task automatic inject(input logic tail);
    int due;
    cascade = tail;
    due = tail ? 4 : 3;
    do_reset();
    for (int e = 0; e < 8; e++) begin
      @(negedge clk);
      rst = 1'b0;
      if (e >= 1) begin
        int edge_n = e - 1;
        if (edge_n == due - 1)
          chk(tail ? "R4 flag not early" : "R3 flag not early", {12'b0, err_n}, {12'b0, 2'b11});
        if (edge_n == due)
          chk(tail ? "R4 flag on due edge R7" : "R3 flag on due edge R7", {12'b0, err_n}, {12'b0, 2'b01});
        if (edge_n == 6)
          chk("R8 flag held", {12'b0, err_n}, {12'b0, 2'b01});
      end
      {cs_a_n, cs_b_n} = (e < 2) ? 2'b00 : 2'b11;
      d_up = '0; p_up = '0; p_dut = '0;
      d_dut = (e == 1) ? 14'h0200 : '0;
    end
  endtask

  initial begin
    run_table(1'b0);
    run_table(1'b1);
    inject(1'b0);
    inject(1'b1);
    // R6: a word in flight when reset arrives never shows up afterwards
    cascade = 1'b0;
    @(negedge clk); {cs_a_n, cs_b_n} = 2'b00; d_dut = 14'h0001; p_dut = 2'b00;
    @(negedge clk); rst = 1'b1; {cs_a_n, cs_b_n} = 2'b11; d_dut = '0;
    @(negedge clk); rst = 1'b0;
    chk("R6 q cleared", q, '0);
    chk("R6 err cleared", {12'b0, err_n}, {12'b0, 2'b11});
    repeat (4) @(negedge clk);
    chk("R6 flushed err", {12'b0, err_n}, {12'b0, 2'b11});
    chk("R6 flushed ppo", {12'b0, ppo}, '0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule